// File: doc/BRIEF.md
# SD Host Internal DMA Engine

This block is the data mover inside an SD card host controller. It has two channels that share one word-wide memory port. The card-bound channel (channel 0) reads 64-bit words from system memory and hands them to the transmit FIFO. The host-bound channel (channel 1) takes words from the receive FIFO and writes them to memory. A transfer covers one contiguous, 8-byte-aligned region whose length is the block count input times the block size.

Software drives the engine through a 64-bit register port, always in the same order. It programs the mode word and the target address, then sets the start bit. It polls or takes an interrupt on the completion and error flags, and writes the status word to clear them. Each channel has its own active-low hold bit. Software pulses a channel by writing the bit low and then high again, which aborts the work in flight on that channel.

Top module: `sddma_top`

## Requirements
- R1: After reset, the reset-control word (0x830) reads 0x0000_0000_FFFF_FFFF, both mask words (0x848, 0x858) read 0x30000 (all sources masked), both status words (0x840, 0x850) read 0, and `irq` is low.
- R2: The mode word (0x820) stores bit 16 (channel: 0 = card-bound, 1 = host-bound), bits 5:4 (bus width) and bit 0 (1 = address increments), and reads back exactly those bits.
- R3: Writing 1 to bit 0 of the control word (0x828) with channel 0 selected reads blk_cnt × BLK_BYTES / 8 words from memory, starting at the address word (0x880). It presents them in order on the transmit port, holding `tx_valid` and `tx_data` until accepted. It then sets bit 16 of status word 0x840.
- R4: A start with channel 1 selected takes the same number of words from the receive port and writes each to memory in arrival order. It then sets bit 17 of 0x840.
- R5: With mode bit 0 clear, every beat of the transfer uses the programmed address. With it set, the address advances by 8 per beat.
- R6: A start whose address has any of bits 2:0 set moves no data and sets the selected channel's bit in error word 0x850 (bit 16 for channel 0, bit 17 for channel 1).
- R7: An error response on the memory port stops the channel. It sets the channel's bit in 0x850 and leaves its end bit in 0x840 clear.
- R8: Bit 8 (channel 0) and bit 9 (channel 1) of 0x830 are active-low holds. While a hold is low, the channel is idle, any transfer is dropped, starts are ignored, and the status bits keep their values. All other bits 31:0 read as 1.
- R9: A start aimed at a channel that is already moving data is ignored. The running transfer finishes with its original address and length.
- R10: Writing a status word replaces its bits 17:16 (writing 0 clears them), and a completion in the same cycle wins. `irq` is the OR of all unmasked status bits, registered one cycle after them. With every mask bit set, `irq` stays low.
- R11: A start with a block count of 0 moves no data and sets the channel's end bit at once.
- R12: The memory port asks only for 8-byte-aligned addresses, and it holds `mem_req` and `mem_addr` steady until `mem_ack` or `mem_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears on the next cycle |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| blk_cnt | input | 32 | Block count captured at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | AW | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Word for the card is valid |
| tx_ready | input | 1 | Transmit FIFO accepts the word |
| tx_data | output | 64 | Word for the card |
| rx_valid | input | 1 | Word from the card is valid |
| rx_ready | output | 1 | Engine accepts a received word |
| rx_data | input | 64 | Word from the card |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The bench builds the engine with BLK_BYTES = 16, so each block is two beats. A multi-block transfer then ends in a few dozen cycles, while the block counter keeps its full width. The memory model holds back every acknowledge by one cycle, so each beat goes through the wait path of the request handshake. With short blocks, one bench run can cover holds, aborts and a start that lands while a channel is busy.

// File: rtl/sddma_pkg.sv
`timescale 1ns/1ps
package sddma_pkg;
  // register byte offsets seen by software
  localparam logic [11:0] OFS_MODE     = 12'h820;
  localparam logic [11:0] OFS_CTRL     = 12'h828;
  localparam logic [11:0] OFS_HOLD     = 12'h830;
  localparam logic [11:0] OFS_DONE     = 12'h840;
  localparam logic [11:0] OFS_DONE_MSK = 12'h848;
  localparam logic [11:0] OFS_FAIL     = 12'h850;
  localparam logic [11:0] OFS_FAIL_MSK = 12'h858;
  localparam logic [11:0] OFS_ADDR     = 12'h880;

  typedef enum logic [1:0] {CS_IDLE, CS_MEM, CS_FIFO} chan_state_e;
endpackage

// File: rtl/sddma_chan.sv
`timescale 1ns/1ps
module sddma_chan
  import sddma_pkg::*;
#(
  parameter bit TO_CARD = 1'b1,
  parameter int AW      = 32,
  parameter int CW      = 38
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          start,
  input  logic          inc,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] beats,
  output logic          done,
  output logic          fail,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [63:0]   mem_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [63:0]   in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data
);
  chan_state_e   st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [63:0]   data_q;
  logic          inc_q;
  logic          last_beat;
  logic          beat_fin;
  logic          launch;

  assign last_beat = (left_q == CW'(1));
  assign launch    = run && (st == CS_IDLE) && start;

  always_comb begin
    if (TO_CARD) beat_fin = run && (st == CS_FIFO) && out_ready;
    else         beat_fin = run && (st == CS_MEM) && mem_ack && !mem_err;
  end

  // control state
  always_ff @(posedge clk) begin
    done <= 1'b0;
    fail <= 1'b0;
    if (rst || !run) begin
      st <= CS_IDLE;
    end else begin
      case (st)
        CS_IDLE: if (start) begin
          if (base[2:0] != 3'd0)  fail <= 1'b1;
          else if (beats == '0)   done <= 1'b1;
          else                    st   <= TO_CARD ? CS_MEM : CS_FIFO;
        end
        CS_MEM: begin
          if (mem_err) begin
            fail <= 1'b1;
            st   <= CS_IDLE;
          end else if (mem_ack) begin
            if (TO_CARD) st <= CS_FIFO;
            else begin
              done <= last_beat;
              st   <= last_beat ? CS_IDLE : CS_FIFO;
            end
          end
        end
        CS_FIFO: begin
          if (TO_CARD && out_ready) begin
            done <= last_beat;
            st   <= last_beat ? CS_IDLE : CS_MEM;
          end else if (!TO_CARD && in_valid) begin
            st <= CS_MEM;
          end
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  // datapath, no reset needed
  always_ff @(posedge clk) begin
    if (launch) begin
      addr_q <= base;
      left_q <= beats;
      inc_q  <= inc;
    end else if (beat_fin) begin
      left_q <= left_q - CW'(1);
      addr_q <= addr_q + (inc_q ? AW'(8) : AW'(0));
    end
    if (TO_CARD && st == CS_MEM && mem_ack)
      data_q <= mem_rdata;
    else if (!TO_CARD && st == CS_FIFO && in_valid)
      data_q <= in_data;
  end

  assign mem_req   = (st == CS_MEM);
  assign mem_we    = !TO_CARD;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign in_ready  = !TO_CARD && (st == CS_FIFO);
  assign out_valid = TO_CARD && (st == CS_FIFO);
  assign out_data  = data_q;
endmodule

// File: rtl/sddma_top.sv
`timescale 1ns/1ps
module sddma_top
  import sddma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [11:0]   reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  input  logic [31:0]   blk_cnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [63:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [63:0]   tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [63:0]   rx_data,
  output logic          irq
);
  localparam int BEATS_PER_BLK = BLK_BYTES / 8;
  localparam int CW            = 32 + $clog2(BEATS_PER_BLK + 1);

  logic          mode_ch, mode_inc;
  logic [1:0]    mode_bw;
  logic [AW-1:0] addr_q;
  logic [1:0]    keep_q, end_q, err_q, end_msk, err_msk;
  logic [1:0]    start_v, done_v, fail_v, req_v, we_v, ack_v, err_v;
  logic [AW-1:0] maddr_v [2];
  logic [63:0]   mwdata_v [2];
  logic [CW-1:0] beats;
  logic          go, lock_q, own_q, sel;
  logic          unused_rdy0, unused_vld1, unused_wdata;
  logic [63:0]   unused_dat1;

  assign unused_wdata = ^reg_wdata;
  assign beats   = CW'(blk_cnt) * CW'(BEATS_PER_BLK);
  assign go      = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];
  assign start_v = go ? (mode_ch ? 2'b10 : 2'b01) : 2'b00;

  // software-visible state
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ch  <= 1'b0;
      mode_inc <= 1'b0;
      mode_bw  <= 2'd0;
      addr_q   <= '0;
      keep_q   <= 2'b11;
      end_q    <= 2'b00;
      err_q    <= 2'b00;
      end_msk  <= 2'b11;
      err_msk  <= 2'b11;
      irq      <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_MODE) begin
        mode_ch  <= reg_wdata[16];
        mode_bw  <= reg_wdata[5:4];
        mode_inc <= reg_wdata[0];
      end
      if (reg_we && reg_addr == OFS_ADDR)     addr_q  <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == OFS_HOLD)     keep_q  <= reg_wdata[9:8];
      if (reg_we && reg_addr == OFS_DONE_MSK) end_msk <= reg_wdata[17:16];
      if (reg_we && reg_addr == OFS_FAIL_MSK) err_msk <= reg_wdata[17:16];
      end_q <= ((reg_we && reg_addr == OFS_DONE) ? reg_wdata[17:16] : end_q) | done_v;
      err_q <= ((reg_we && reg_addr == OFS_FAIL) ? reg_wdata[17:16] : err_q) | fail_v;
      irq   <= |((end_q & ~end_msk) | (err_q & ~err_msk));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) begin
      case (reg_addr)
        OFS_MODE:     reg_rdata <= {47'd0, mode_ch, 10'd0, mode_bw, 3'd0, mode_inc};
        OFS_HOLD:     reg_rdata <= {32'd0, 22'h3F_FFFF, keep_q, 8'hFF};
        OFS_DONE:     reg_rdata <= {46'd0, end_q, 16'd0};
        OFS_DONE_MSK: reg_rdata <= {46'd0, end_msk, 16'd0};
        OFS_FAIL:     reg_rdata <= {46'd0, err_q, 16'd0};
        OFS_FAIL_MSK: reg_rdata <= {46'd0, err_msk, 16'd0};
        OFS_ADDR:     reg_rdata <= 64'(addr_q);
        default:      reg_rdata <= '0;
      endcase
    end
  end

  // shared memory port: channel 0 first, owner locked while a request waits
  assign sel       = lock_q ? own_q : !req_v[0];
  assign mem_req   = req_v[sel];
  assign mem_we    = we_v[sel];
  assign mem_addr  = maddr_v[sel];
  assign mem_wdata = mwdata_v[sel];
  assign ack_v     = sel ? {mem_ack, 1'b0} : {1'b0, mem_ack};
  assign err_v     = sel ? {mem_err, 1'b0} : {1'b0, mem_err};

  always_ff @(posedge clk) begin
    lock_q <= !rst && mem_req && !mem_ack && !mem_err;
    own_q  <= sel;
  end

  sddma_chan #(.TO_CARD(1'b1), .AW(AW), .CW(CW)) u_ch0 (
    .clk(clk), .rst(rst), .run(keep_q[0]), .start(start_v[0]), .inc(mode_inc),
    .base(addr_q), .beats(beats), .done(done_v[0]), .fail(fail_v[0]),
    .mem_req(req_v[0]), .mem_we(we_v[0]), .mem_addr(maddr_v[0]),
    .mem_wdata(mwdata_v[0]), .mem_ack(ack_v[0]), .mem_err(err_v[0]),
    .mem_rdata(mem_rdata), .in_valid(1'b0), .in_ready(unused_rdy0),
    .in_data(64'd0), .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data)
  );

  sddma_chan #(.TO_CARD(1'b0), .AW(AW), .CW(CW)) u_ch1 (
    .clk(clk), .rst(rst), .run(keep_q[1]), .start(start_v[1]), .inc(mode_inc),
    .base(addr_q), .beats(beats), .done(done_v[1]), .fail(fail_v[1]),
    .mem_req(req_v[1]), .mem_we(we_v[1]), .mem_addr(maddr_v[1]),
    .mem_wdata(mwdata_v[1]), .mem_ack(ack_v[1]), .mem_err(err_v[1]),
    .mem_rdata(mem_rdata), .in_valid(rx_valid), .in_ready(rx_ready),
    .in_data(rx_data), .out_valid(unused_vld1), .out_ready(1'b0), .out_data(unused_dat1)
  );
endmodule

// File: rtl/sddma_top_chk.sv
`timescale 1ns/1ps
module sddma_top_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [63:0]   tx_data,
  input logic [1:0]    keep_q,
  input logic [1:0]    end_msk,
  input logic [1:0]    err_msk,
  input logic          irq
);
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[2:0] == 3'd0); // R12

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mem_err && keep_q == 2'b11)
    |=> ((mem_req && $stable(mem_addr)) || keep_q != 2'b11)); // R12

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && keep_q[0])
    |=> ((tx_valid && $stable(tx_data)) || !keep_q[0])); // R3

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!keep_q[0] && $past(!keep_q[0])) |-> !tx_valid); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(end_msk) == 2'b11 && $past(err_msk) == 2'b11) |-> !irq); // R10
endmodule

bind sddma_top sddma_top_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
  .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .keep_q(keep_q), .end_msk(end_msk), .err_msk(err_msk), .irq(irq)
);

// File: tb/sddma_top_bench.sv
`timescale 1ns/1ps
module sddma_top_bench;
  import sddma_pkg::*;
  localparam int AW = 32;
  localparam int BLK_BYTES = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [63:0]   reg_wdata = '0, reg_rdata;
  logic [31:0]   blk_cnt = '0;
  logic          mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata = '0;
  logic          tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, irq;
  logic [63:0]   tx_data, rx_data = '0;

  sddma_top #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_sddma_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_cnt(blk_cnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  int tx_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] exp_a0 = '0, exp_a1 = '0, held_addr = '0;
  bit inc0 = 1'b1, inc1 = 1'b1, tx_en = 1'b1, rx_en = 1'b1, err_next = 1'b0, gap = 1'b0;
  logic [63:0] rx_q[$];
  logic [63:0] wexp_q[$];

  function automatic logic [63:0] pat(input logic [AW-1:0] a);
    return {a ^ 32'hA5C3_0000, ~a};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory and FIFO models, driven away from the active edge
  always @(negedge clk) begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    if (rst || !mem_req) gap = 1'b0;
    else if (!gap) begin
      gap = 1'b1;
      held_addr = mem_addr;
    end else begin
      gap = 1'b0;
      chk("R12 request held", 64'(mem_addr), 64'(held_addr));
      if (err_next) begin
        mem_err = 1'b1; err_next = 1'b0;
      end else begin
        mem_ack = 1'b1;
        if (mem_we) begin
          chk("R4/R5 write address", 64'(mem_addr), 64'(exp_a1));
          chk("R4 write data", mem_wdata, (wexp_q.size() > 0) ? wexp_q.pop_front() : 64'hDEAD);
          exp_a1 = exp_a1 + (inc1 ? 32'd8 : 32'd0);
          wr_cnt++;
        end else begin
          mem_rdata = pat(mem_addr);
        end
      end
    end
    tx_ready = 1'b0;
    if (!rst && tx_valid && tx_en) begin
      tx_ready = 1'b1;
      chk("R3/R5 transmit word", tx_data, pat(exp_a0));
      exp_a0 = exp_a0 + (inc0 ? 32'd8 : 32'd0);
      tx_cnt++;
    end
    rx_valid = 1'b0; rx_data = '0;
    if (!rst && rx_ready && rx_en && rx_q.size() > 0) begin
      rx_valid = 1'b1;
      rx_data = rx_q.pop_front();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_bit(input logic [11:0] a, input int b);
    logic [63:0] d;
    for (int i = 0; i < 300; i++) begin
      rd(a, d);
      if (d[b]) break;
    end
  endtask

  task automatic launch(input bit ch, input bit inc, input logic [AW-1:0] a, input int nblk);
    blk_cnt = nblk;
    wr(OFS_MODE, {47'd0, ch, 10'd0, 2'b11, 3'd0, inc});
    wr(OFS_ADDR, 64'(a));
    wr(OFS_CTRL, 64'd1);
  endtask

  task automatic fill_rx(input int n, input logic [63:0] seed);
    for (int i = 0; i < n; i++) begin
      rx_q.push_back(seed + 64'(i) * 64'h0101);
      wexp_q.push_back(seed + 64'(i) * 64'h0101);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq low", 64'(irq), 64'd0);
    rd(OFS_HOLD, d);     chk("R1 hold word", d, 64'h0000_0000_FFFF_FFFF);
    rd(OFS_DONE_MSK, d); chk("R1 end mask", d, 64'h30000);
    rd(OFS_FAIL_MSK, d); chk("R1 error mask", d, 64'h30000);
    rd(OFS_DONE, d);     chk("R1 end status", d, 64'd0);
    rd(OFS_FAIL, d);     chk("R1 error status", d, 64'd0);
    // R2 mode readback
    wr(OFS_MODE, 64'hFFFF_0000_0001_0021);
    rd(OFS_MODE, d);     chk("R2 mode readback", d, 64'h10021);
    // R3 card-bound, two blocks, incrementing
    tx_cnt = 0; exp_a0 = 32'h1000; inc0 = 1'b1;
    launch(1'b0, 1'b1, 32'h1000, 2);
    wait_bit(OFS_DONE, 16);
    chk("R3 beat count", 64'(tx_cnt), 64'd4);
    rd(OFS_FAIL, d);     chk("R3 no error", d, 64'd0);
    chk("R10 masked irq", 64'(irq), 64'd0);
    // R10 unmask and clear
    wr(OFS_DONE_MSK, 64'h20000);
    @(negedge clk);
    chk("R10 irq raised", 64'(irq), 64'd1);
    wr(OFS_DONE, 64'd0);
    @(negedge clk);
    chk("R10 irq after clear", 64'(irq), 64'd0);
    rd(OFS_DONE, d);     chk("R10 status cleared", d, 64'd0);
    wr(OFS_DONE_MSK, 64'hFFFF_FFFF_FFFF_FFFF);
    // R4 host-bound, three blocks
    wr_cnt = 0; exp_a1 = 32'h2000; inc1 = 1'b1;
    fill_rx(6, 64'h1111_0000_0000_0000);
    launch(1'b1, 1'b1, 32'h2000, 3);
    wait_bit(OFS_DONE, 17);
    chk("R4 write count", 64'(wr_cnt), 64'd6);
    chk("R4 receive drained", 64'(rx_q.size()), 64'd0);
    wr(OFS_DONE, 64'd0);
    // R5 fixed address
    tx_cnt = 0; exp_a0 = 32'h3000; inc0 = 1'b0;
    launch(1'b0, 1'b0, 32'h3000, 1);
    wait_bit(OFS_DONE, 16);
    chk("R5 beat count", 64'(tx_cnt), 64'd2);
    wr(OFS_DONE, 64'd0);
    inc0 = 1'b1;
    // R6 misaligned start
    wr_cnt = 0; exp_a1 = 32'h4004;
    fill_rx(4, 64'h2222_0000_0000_0000);
    launch(1'b1, 1'b1, 32'h4004, 2);
    wait_bit(OFS_FAIL, 17);
    repeat (20) @(negedge clk);
    chk("R6 nothing written", 64'(wr_cnt), 64'd0);
    chk("R6 nothing consumed", 64'(rx_q.size()), 64'd4);
    rd(OFS_FAIL, d);     chk("R6 error bit", d, 64'h20000);
    rd(OFS_DONE, d);     chk("R6 no end bit", d, 64'd0);
    rx_q.delete(); wexp_q.delete();
    wr(OFS_FAIL, 64'd0);
    // R7 memory error
    tx_cnt = 0; exp_a0 = 32'h5000; err_next = 1'b1;
    launch(1'b0, 1'b1, 32'h5000, 2);
    wait_bit(OFS_FAIL, 16);
    repeat (10) @(negedge clk);
    chk("R7 no request after error", 64'(mem_req), 64'd0);
    chk("R7 no beats", 64'(tx_cnt), 64'd0);
    rd(OFS_DONE, d);     chk("R7 end bit clear", d, 64'd0);
    wr(OFS_FAIL, 64'd0);
    // R11 zero blocks
    tx_cnt = 0;
    launch(1'b0, 1'b1, 32'h5800, 0);
    wait_bit(OFS_DONE, 16);
    repeat (5) @(negedge clk);
    chk("R11 no beats", 64'(tx_cnt), 64'd0);
    wr(OFS_DONE, 64'd0);
    // R9 start while busy
    tx_en = 1'b0; tx_cnt = 0; exp_a0 = 32'h6000;
    launch(1'b0, 1'b1, 32'h6000, 1);
    repeat (10) @(negedge clk);
    launch(1'b0, 1'b1, 32'h7000, 4);
    tx_en = 1'b1;
    wait_bit(OFS_DONE, 16);
    repeat (20) @(negedge clk);
    chk("R9 original length only", 64'(tx_cnt), 64'd2);
    wr(OFS_DONE, 64'd0);
    // R8 hold aborts, keeps status, blocks starts
    wr(OFS_DONE, 64'h20000);
    rx_en = 1'b0; wr_cnt = 0;
    launch(1'b1, 1'b1, 32'h8000, 2);
    repeat (5) @(negedge clk);
    chk("R8 channel busy before hold", 64'(rx_ready), 64'd1);
    wr(OFS_HOLD, 64'hFFFF_FDFF);
    repeat (3) @(negedge clk);
    chk("R8 held channel idle", 64'(rx_ready), 64'd0);
    rd(OFS_DONE, d);     chk("R8 end status kept", d, 64'h20000);
    rd(OFS_FAIL, d);     chk("R8 error status kept", d, 64'd0);
    rd(OFS_HOLD, d);     chk("R8 hold readback", d, 64'h0000_0000_FFFF_FDFF);
    fill_rx(2, 64'h3333_0000_0000_0000);
    rx_en = 1'b1; exp_a1 = 32'h9000;
    launch(1'b1, 1'b1, 32'h9000, 1);
    repeat (10) @(negedge clk);
    chk("R8 start ignored in hold", 64'(wr_cnt), 64'd0);
    chk("R8 nothing consumed in hold", 64'(rx_q.size()), 64'd2);
    wr(OFS_HOLD, 64'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    chk("R8 idle after release", 64'(rx_ready), 64'd0);
    wr(OFS_DONE, 64'd0);
    launch(1'b1, 1'b1, 32'h9000, 1);
    wait_bit(OFS_DONE, 17);
    chk("R8 transfer after release", 64'(wr_cnt), 64'd2);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule